// File: doc/BRIEF.md
# Fuse Memory Word Read Sequencer

This block reads a run of 32-bit words out of a one-time-programmable fuse macro. It drives the macro's pins directly instead of going through a synchronous RAM port. A request gives a byte offset and a byte size. The block first checks both values. It rejects the request if either value is not a whole number of words, or if any part of the run falls outside the array.

An accepted request starts with an ordered power-up of the macro: wake it from deep standby, then enable trim, then enable the chip. For each word the block then:

- puts the word index on the address pins;
- holds the macro clock high for the read-access time;
- holds it low for the clock-low time;
- captures the data pins.

Each captured word leaves on a valid/ready stream. While the consumer is not ready, the sequencer waits with the macro clock low. After the last word it powers the macro down in the reverse order and pulses `done`.

Both clock phases are given in microseconds and turned into cycle counts from the system clock frequency parameter. The standby pin is active low, so 1 means awake.

Top module: `otp_rd_seq`

## Requirements
- R1: A request is rejected when offset bits [1:0] are non-zero, when size bits [1:0] are non-zero, when the start word (offset/4) is at or beyond `WORDS`, or when start word plus word count (size/4) exceeds `WORDS`. A rejection gives a one-cycle `err` pulse in the cycle after the request. `busy` stays low and no macro pin moves.
- R2: On an accepted request, `fz_wake` rises in the cycle after the request. `fz_trim` rises one cycle later, while `fz_en` is still low. `fz_en` rises one cycle after that.
- R3: Before each rising edge of `fz_clk`, `fz_addr` already holds start word plus the number of words read so far. It stays stable while `fz_clk` is high. `fz_clk` is only ever high while wake, trim and enable are all high.
- R4: Each high phase of `fz_clk` lasts exactly `TCD_US*CLK_MHZ` cycles.
- R5: After each falling edge of `fz_clk`, the clock stays low for exactly `TKL_US*CLK_MHZ` cycles. The word is then presented on `out_valid`.
- R6: The presented word equals `fz_dout` as sampled at the end of the low phase. Words come out in increasing index order, exactly size/4 of them.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `fz_clk` stays low.
- R8: Shutdown drops `fz_en` first, then `fz_trim` one cycle later, then `fz_wake` one cycle after that.
- R9: `busy` is high from the cycle after acceptance until shutdown completes. Requests that arrive while busy are ignored.
- R10: `done` is a one-cycle pulse in the same cycle that `fz_wake` falls, with `busy` already low.
- R11: A valid request of size 0 powers the macro up and down, presents no word and still pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_offset | input | AW+3 | Byte offset of the first word |
| req_size | input | AW+3 | Byte size of the run |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after shutdown |
| err | output | 1 | One-cycle pulse for a rejected request |
| fz_wake | output | 1 | Deep-standby pin, active low (1 = awake) |
| fz_trim | output | 1 | Trim enable pin |
| fz_en | output | 1 | Chip enable pin |
| fz_clk | output | 1 | Macro clock pin |
| fz_addr | output | AW | Macro word address pins |
| fz_dout | input | 32 | Macro read data pins |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 32 | Captured word |

## Verification
Every start word of a 16-word array is combined with every run length that fits, from zero up to the end of the array. Each mismatch therefore points at an address-increment, count or end-boundary fault. Runs alternate between a consumer that is always ready and one that stalls every third cycle, which separates correct holding of the word from losing or repeating a word. The modelled macro returns a decoy value while its clock is high, so a capture at the wrong moment shows up as wrong data. Misaligned offsets and sizes, starts past the end and runs that overflow the end are checked for a lone error pulse with quiet pins, and one run receives a second request while busy.

// File: rtl/otp_rd_pkg.sv
// Package: shared state encoding for the fuse read sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package otp_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_TRIM,
        ST_PU_EN,
        ST_ADDR,
        ST_HIGH,
        ST_LOW,
        ST_PRESENT,
        ST_SD_EN,
        ST_SD_TRIM,
        ST_SD_WAKE
    } seq_state_t;

endpackage

// File: rtl/otp_req_check.sv
// Module: otp_req_check
// Decodes a byte offset/size request into start word and word count and
// flags alignment and range violations. Purely combinational.
// Assumes: BW = AW + 3 so any start and count up to 2*WORDS are representable.
module otp_req_check #(
    parameter int WORDS = 4096,
    parameter int AW    = $clog2(WORDS),
    parameter int BW    = AW + 3
) (
    input  logic [BW-1:0] offset,
    input  logic [BW-1:0] size,
    output logic          bad,
    output logic [AW-1:0] start_idx,
    output logic [AW:0]   word_cnt
);
    localparam logic [AW+1:0] TOTAL = (AW+2)'(WORDS);

    logic [AW:0]   idx_full;
    logic [AW+1:0] end_idx;

    // Split byte quantities into word quantities and test the bounds.
    always_comb begin
        idx_full  = offset[BW-1:2];
        word_cnt  = size[BW-1:2];
        start_idx = idx_full[AW-1:0];
        end_idx   = {1'b0, idx_full} + {1'b0, word_cnt};
        bad       = (|offset[1:0]) || (|size[1:0]) ||
                    ({1'b0, idx_full} >= TOTAL) || (end_idx > TOTAL);
    end

endmodule

// File: rtl/otp_phase_timer.sv
// Module: otp_phase_timer
// Down-counter timing one clock phase of the macro. Loading N-1 makes
// `zero` rise after N cycles in the timed state.
// Assumes: load has priority; counter rests at zero.
module otp_phase_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag seen by the sequencer.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/otp_rd_seq.sv
// Module: otp_rd_seq (top)
// Reads a run of fuse words: checks the request, powers the macro up
// (wake, trim, enable), clocks each word with timed high/low phases,
// streams words out over valid/ready and powers down in reverse order.
// Assumes: TCD_US*CLK_MHZ >= 1 and TKL_US*CLK_MHZ >= 1; all pins registered.
module otp_rd_seq
    import otp_rd_pkg::*;
#(
    parameter int WORDS   = 4096,
    parameter int DW      = 32,
    parameter int CLK_MHZ = 100,
    parameter int TCD_US  = 40,
    parameter int TKL_US  = 10,
    parameter int AW      = $clog2(WORDS),
    parameter int BW      = AW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [BW-1:0] req_offset,
    input  logic [BW-1:0] req_size,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          fz_wake,
    output logic          fz_trim,
    output logic          fz_en,
    output logic          fz_clk,
    output logic [AW-1:0] fz_addr,
    input  logic [DW-1:0] fz_dout,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int HI_CYC = TCD_US * CLK_MHZ;
    localparam int LO_CYC = TKL_US * CLK_MHZ;
    localparam int MAXCYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int TW     = $clog2(MAXCYC + 1);
    localparam logic [TW-1:0] HI_LOAD = TW'(HI_CYC - 1);
    localparam logic [TW-1:0] LO_LOAD = TW'(LO_CYC - 1);

    seq_state_t    state_q;
    logic          chk_bad;
    logic [AW-1:0] chk_idx;
    logic [AW:0]   chk_cnt;
    logic [AW-1:0] idx_q;
    logic [AW:0]   left_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    otp_req_check #(.WORDS(WORDS), .AW(AW), .BW(BW)) u_check (
        .offset    (req_offset),
        .size      (req_size),
        .bad       (chk_bad),
        .start_idx (chk_idx),
        .word_cnt  (chk_cnt)
    );

    // Timer loads the high phase on entry and the low phase at its end.
    always_comb begin
        tmr_load = (state_q == ST_ADDR) || (state_q == ST_HIGH && tmr_zero);
        tmr_val  = (state_q == ST_ADDR) ? HI_LOAD : LO_LOAD;
    end

    otp_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Main sequencer: power-up, per-word clocking, hand-off, shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            fz_wake   <= 1'b0;
            fz_trim   <= 1'b0;
            fz_en     <= 1'b0;
            fz_clk    <= 1'b0;
            fz_addr   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            idx_q     <= '0;
            left_q    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid && chk_bad) begin
                        err <= 1'b1;
                    end else if (req_valid) begin
                        busy    <= 1'b1;
                        fz_wake <= 1'b1;
                        idx_q   <= chk_idx;
                        left_q  <= chk_cnt;
                        state_q <= ST_PU_TRIM;
                    end
                end
                ST_PU_TRIM: begin
                    fz_trim <= 1'b1;
                    state_q <= ST_PU_EN;
                end
                ST_PU_EN: begin
                    fz_en   <= 1'b1;
                    fz_addr <= idx_q;
                    state_q <= (left_q == '0) ? ST_SD_EN : ST_ADDR;
                end
                ST_ADDR: begin
                    fz_clk  <= 1'b1;
                    state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tmr_zero) begin
                        fz_clk  <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tmr_zero) begin
                        out_data  <= fz_dout;
                        out_valid <= 1'b1;
                        state_q   <= ST_PRESENT;
                    end
                end
                ST_PRESENT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        idx_q     <= idx_q + 1'b1;
                        left_q    <= left_q - 1'b1;
                        fz_addr   <= idx_q + 1'b1;
                        state_q   <= (left_q == (AW+1)'(1)) ? ST_SD_EN : ST_ADDR;
                    end
                end
                ST_SD_EN: begin
                    fz_en   <= 1'b0;
                    state_q <= ST_SD_TRIM;
                end
                ST_SD_TRIM: begin
                    fz_trim <= 1'b0;
                    state_q <= ST_SD_WAKE;
                end
                ST_SD_WAKE: begin
                    fz_wake <= 1'b0;
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ERR_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !fz_wake && !fz_trim && !fz_en && !busy); // R1
    AST_EN_AFTER_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_en) |-> fz_trim && fz_wake); // R2
    AST_TRIM_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fz_trim) |-> fz_wake && !fz_en); // R2
    AST_CLK_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        fz_clk |-> fz_wake && fz_trim && fz_en); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fz_clk && $past(fz_clk)) |-> $stable(fz_addr)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && !fz_clk); // R7
    AST_TRIM_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fz_trim) |-> !fz_en && fz_wake); // R8
    AST_WAKE_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fz_wake) |-> !fz_trim && !fz_en); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !fz_wake); // R10

endmodule

// File: tb/tb_otp_rd_seq.sv
module tb_otp_rd_seq;
    localparam int PERIOD = 10;
    localparam int WORDS  = 16;
    localparam int AW     = 4;
    localparam int BW     = AW + 3;
    localparam int HI     = 40;
    localparam int LO     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_offset = '0;
    logic [BW-1:0] req_size = '0;
    logic          busy, done, err;
    logic          fz_wake, fz_trim, fz_en, fz_clk;
    logic [AW-1:0] fz_addr;
    logic [31:0]   fz_dout;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [31:0]   out_data;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    otp_rd_seq #(.WORDS(WORDS), .CLK_MHZ(1), .TCD_US(40), .TKL_US(10)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_size(req_size), .busy(busy), .done(done), .err(err),
        .fz_wake(fz_wake), .fz_trim(fz_trim), .fz_en(fz_en), .fz_clk(fz_clk),
        .fz_addr(fz_addr), .fz_dout(fz_dout), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] fdata(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    // Macro model: decoy while clock high, word data while low.
    always_comb fz_dout = fz_clk ? 32'hDEAD_BEEF : fdata(int'(fz_addr));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pin monitor: timing and ordering of the macro pins.
    int mon_start = 0;
    int rises = 0;
    int hi_len = 0;
    int lo_len = 0;
    bit in_low = 0;
    logic p_clk = 0, p_wake = 0, p_trim = 0, p_en = 0;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fz_clk && !p_clk) begin
                chk(fz_addr == AW'(mon_start + rises), "R3 addr at rise", fz_addr, AW'(mon_start + rises));
                chk(fz_addr == p_addr, "R3 addr setup", fz_addr, p_addr);
                rises++;
                hi_len = 1;
            end else if (fz_clk) begin
                hi_len++;
                if (fz_addr != p_addr) chk(0, "R3 addr stable", fz_addr, p_addr);
            end
            if (!fz_clk && p_clk) begin
                chk(hi_len == HI, "R4 high length", hi_len, HI);
                in_low = 1;
                lo_len = 1;
            end else if (in_low && !fz_clk && !out_valid) begin
                lo_len++;
            end
            if (in_low && out_valid) begin
                chk(lo_len == LO, "R5 low length", lo_len, LO);
                in_low = 0;
            end
            if (fz_clk && !(fz_wake && fz_trim && fz_en)) chk(0, "R3 clk unpowered", 0, 1);
            if (out_valid && fz_clk) chk(0, "R7 clk during stall", 1, 0);
            if (fz_trim && !p_trim) chk(p_wake && fz_wake && !fz_en, "R2 trim rise", {fz_wake, fz_en}, 2'b10);
            if (fz_en && !p_en) chk(p_trim && fz_trim && fz_wake, "R2 en rise", {fz_trim, fz_wake}, 2'b11);
            if (fz_wake && !p_wake) chk(!fz_trim && !fz_en && busy, "R2 wake rise", {fz_trim, fz_en, busy}, 3'b001);
            if (!fz_en && p_en) chk(fz_trim && fz_wake, "R8 en fall", {fz_trim, fz_wake}, 2'b11);
            if (!fz_trim && p_trim) chk(!fz_en && fz_wake && !p_en, "R8 trim fall", {fz_en, fz_wake}, 2'b01);
            if (!fz_wake && p_wake) chk(!fz_trim && !p_trim && done && !busy, "R10 wake fall",
                                        {fz_trim, done, busy}, 3'b010);
        end
        p_clk = fz_clk; p_wake = fz_wake; p_trim = fz_trim; p_en = fz_en; p_addr = fz_addr;
    end

    task automatic bad_req(input int off, input int sz);
        @(negedge clk);
        req_valid = 1; req_offset = BW'(off); req_size = BW'(sz);
        @(negedge clk);
        req_valid = 0;
        chk(err == 1, "R1 err pulse", err, 1);
        chk(!busy && !fz_wake && !fz_trim && !fz_en, "R1 quiet pins",
            {busy, fz_wake, fz_trim, fz_en}, 0);
        @(negedge clk);
        chk(err == 0 && !busy && !fz_wake, "R1 err single", {err, busy, fz_wake}, 0);
    endtask

    task automatic run_req(input int start, input int cnt, input int mode, input bit inject);
        int got = 0;
        int cyc = 0;
        bit dn = 0;
        @(negedge clk);
        mon_start = start; rises = 0;
        req_valid = 1; req_offset = BW'(start * 4); req_size = BW'(cnt * 4);
        @(negedge clk);
        req_valid = 0;
        chk(busy && fz_wake && !fz_trim, "R9 busy on accept", {busy, fz_wake, fz_trim}, 3'b110);
        while (!dn && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 20) begin
                req_valid = 1; req_offset = BW'(4); req_size = BW'(8);
            end else begin
                req_valid = 0;
            end
            out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (out_valid && out_ready) begin
                chk(out_data == fdata(start + got), "R6 word data", out_data, fdata(start + got));
                got++;
            end
            if (done) dn = 1;
            else if (!busy) chk(0, "R9 busy dropped early", busy, 1);
        end
        out_ready = 0;
        chk(dn, "R10 done seen", dn, 1);
        chk(got == cnt, cnt == 0 ? "R11 zero-size words" : "R6 word count", got, cnt);
        @(negedge clk);
        chk(!done, "R10 done single cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !fz_wake && !out_valid, "R9 idle after run (ignored request)",
            {busy, fz_wake, out_valid}, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({busy, done, err, fz_wake, fz_trim, fz_en, fz_clk, out_valid} == 0,
            "reset state", {busy, done, err, fz_wake, fz_trim, fz_en, fz_clk, out_valid}, 0);

        // R1: alignment and range rejections.
        bad_req(1, 4);
        bad_req(2, 4);
        bad_req(3, 4);
        bad_req(0, 2);
        bad_req(8, 7);
        for (int s = WORDS; s < 2 * WORDS; s += 5) bad_req(s * 4, 0);
        bad_req(40, 28);
        bad_req(0, 68);
        bad_req(60, 8);

        // Sweep every start word with every run length that fits.
        for (int s = 0; s < WORDS; s++)
            for (int c = 0; c <= WORDS - s; c++)
                run_req(s, c, (s + c) % 2, 1'b0);

        // R9: request arriving while busy is ignored.
        run_req(8, 4, 1, 1'b1);
        run_req(0, 0, 0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule